// File: doc/BRIEF.md
# Clock-Domain Register Transfer with Freeze Batching

This block carries software writes to four configuration registers from a fast bus clock domain into a slow counting clock domain. Each register keeps a bus-side copy. A write goes into that copy, and the value then travels to the slow side through its own toggle request/acknowledge handshake. The handshake uses two-flop synchronisers in both directions. A per-register busy bit stays high from the write until the acknowledge returns. Software polls the busy bits before it depends on a slow-side value.

A freeze input lets software stage several writes and release them together. While freeze is high, writes only update the bus-side copies. When freeze falls, every staged register launches in the same bus cycle.

Two rules of the counting logic are kept. First, the counter reset-enable bit of the control register bypasses the handshake entirely and drives the slow domain directly. Second, a control value is never delivered ahead of a top-value write made before it. The command register is delivered as a single-cycle pulse in the slow domain.

Top module: `rsync_bridge`

## Requirements
- R1: Register select codes are 0 = control, 1 = top value, 2 = command, 3 = filter configuration. The busy vector uses the same bit index for each register. A write (`wr_en` high at a `clk_bus` edge) sets that register's busy bit at that edge.
- R2: The bus side launches a written value one bus cycle after the write, provided the register is idle and not frozen. The value appears on the slow-side output after at most 3 rising `clk_cnt` edges following the launch. Once the acknowledge returns, the busy bit clears.
- R3: While `freeze` is high, writes update the bus-side copies and set their busy bits, but no slow-side register output changes.
- R4: When `freeze` falls, all staged registers launch in the same bus cycle. They appear on the slow side at the same `clk_cnt` edge.
- R5: Bit `RSTEN_BIT` (default 7) of the control register drives `cnt_rsten` one bus edge after the write, without synchronisation. This also happens while frozen, and the control busy bit is still set.
- R6: A top-value write made before a control write is visible on the slow side no later than that control value. The control launch waits while a top-value write is staged and not launching.
- R7: A write to a register that is still busy is kept. It is re-sent after the current transfer completes, and the busy bit stays set until the final value has arrived. The slow-side output ends at the last value written.
- R8: The command output `cnt_cmd` carries the written value for exactly one `clk_cnt` cycle and is zero otherwise.
- R9: After reset the busy vector, all slow-side outputs and `cnt_rsten` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bus | input | 1 | Fast bus clock |
| rst_bus | input | 1 | Synchronous active-high reset, bus domain |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 control, 1 top, 2 command, 3 filter) |
| wr_data | input | DATA_W | Write data |
| freeze | input | 1 | Hold staged writes on the bus side while high |
| busy | output | 4 | Per-register transfer in progress |
| clk_cnt | input | 1 | Slow counting clock |
| rst_cnt | input | 1 | Synchronous active-high reset, slow domain |
| cnt_ctrl | output | DATA_W | Control register, slow domain |
| cnt_top | output | DATA_W | Top value register, slow domain |
| cnt_cmd | output | DATA_W | Command pulse, slow domain |
| cnt_filt | output | DATA_W | Filter configuration, slow domain |
| cnt_rsten | output | 1 | Unsynchronised counter reset enable |

## Verification
The main collision is between a returning acknowledge and a new write to the same register in the same bus cycle. The bench provokes it by writing a register twice on consecutive bus cycles. It then requires the busy bit to stay high at every bus cycle until the second value is on the slow output.

A second collision is between a freeze release and a blocked control launch. Control and top value are staged together under freeze and released at once. The bench then requires the first slow edge that shows any new value to show all of them.

The ordering rule is judged by staging a second top-value write behind one in flight and following it with a control write. At no slow edge may the new control value be visible beside the old top value.

// File: rtl/rsync_pkg.sv
package rsync_pkg;

    localparam int NUM_REG  = 4;
    localparam int SEL_W    = 2;

    localparam int IDX_CTRL = 0;
    localparam int IDX_TOPB = 1;
    localparam int IDX_CMD  = 2;
    localparam int IDX_FILT = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_TOPB = 2'd1,
        SEL_CMD  = 2'd2,
        SEL_FILT = 2'd3
    } reg_sel_e;

    // Registers delivered as one-cycle pulses on the slow side
    function automatic logic is_pulse_reg(int idx);
        return idx == IDX_CMD;
    endfunction

    // Registers that must not launch ahead of a staged predecessor
    function automatic logic [NUM_REG-1:0] pred_mask(int idx);
        logic [NUM_REG-1:0] m;
        m = '0;
        if (idx == IDX_CTRL) m[IDX_TOPB] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/rsync_sync2.sv
module rsync_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/rsync_chan.sv
module rsync_chan #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         hold,
    input  logic         block,
    input  logic         ack_i,
    output logic         req_o,
    output logic [W-1:0] data_o,
    output logic         busy_o,
    output logic         stall_o
);
    logic [W-1:0] shadow_q;
    logic [W-1:0] sent_q;
    logic         pend_q;
    logic         infl_q;
    logic         req_q;
    logic         ack_s;
    logic         done;
    logic         free;
    logic         go;
    logic         launch;

    rsync_sync2 #(.W(1)) u_ack (
        .clk (clk),
        .rst (rst),
        .d   (ack_i),
        .q   (ack_s)
    );

    assign done   = infl_q && (ack_s == req_q);
    assign free   = !infl_q || done;
    assign go     = pend_q && free && !hold;
    assign launch = go && !block;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            sent_q   <= '0;
            pend_q   <= 1'b0;
            infl_q   <= 1'b0;
            req_q    <= 1'b0;
        end else begin
            if (wr) begin
                shadow_q <= wdata;
                pend_q   <= 1'b1;
            end else if (launch) begin
                pend_q   <= 1'b0;
            end
            if (launch) begin
                req_q  <= ~req_q;
                sent_q <= shadow_q;
                infl_q <= 1'b1;
            end else if (done) begin
                infl_q <= 1'b0;
            end
        end
    end

    assign req_o   = req_q;
    assign data_o  = sent_q;
    assign busy_o  = pend_q || infl_q;
    assign stall_o = pend_q && !go;

    // R1
    busy_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> busy_o);

    // R2
    ack_only_inflight_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_s != $past(ack_s)) |-> $past(infl_q));
endmodule

// File: rtl/rsync_dst.sv
module rsync_dst #(
    parameter int W     = 8,
    parameter bit PULSE = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req_i,
    input  logic [W-1:0] data_i,
    output logic         ack_o,
    output logic [W-1:0] q_o
);
    logic         req_s;
    logic         seen_q;
    logic         capture;
    logic [W-1:0] val_q;

    rsync_sync2 #(.W(1)) u_req (
        .clk (clk),
        .rst (rst),
        .d   (req_i),
        .q   (req_s)
    );

    assign capture = req_s != seen_q;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else if (capture) seen_q <= req_s;
    end

    generate
        if (PULSE) begin : g_pulse
            always_ff @(posedge clk) begin
                if (rst) val_q <= '0;
                else     val_q <= capture ? data_i : '0;
            end

            // R8
            cmd_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
                (val_q != '0) |=> (val_q == '0));
        end else begin : g_level
            always_ff @(posedge clk) begin
                if (rst) val_q <= '0;
                else if (capture) val_q <= data_i;
            end
        end
    endgenerate

    assign ack_o = seen_q;
    assign q_o   = val_q;
endmodule

// File: rtl/rsync_bridge.sv
module rsync_bridge
    import rsync_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int RSTEN_BIT = 7
) (
    input  logic                 clk_bus,
    input  logic                 rst_bus,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 freeze,
    output logic [NUM_REG-1:0]   busy,
    input  logic                 clk_cnt,
    input  logic                 rst_cnt,
    output logic [DATA_W-1:0]    cnt_ctrl,
    output logic [DATA_W-1:0]    cnt_top,
    output logic [DATA_W-1:0]    cnt_cmd,
    output logic [DATA_W-1:0]    cnt_filt,
    output logic                 cnt_rsten
);
    logic [NUM_REG-1:0] wr_hit;
    logic [NUM_REG-1:0] req_vec;
    logic [NUM_REG-1:0] ack_vec;
    logic [NUM_REG-1:0] stall;
    logic [NUM_REG-1:0] blk;
    logic [DATA_W-1:0]  xfer_data [NUM_REG];
    logic [DATA_W-1:0]  slow_q    [NUM_REG];
    logic               rsten_q;
    reg_sel_e           sel;

    assign sel = reg_sel_e'(wr_sel);

    generate
        for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
            assign wr_hit[i] = wr_en && (sel == reg_sel_e'(i));
            assign blk[i]    = |(stall & pred_mask(i));

            rsync_chan #(.W(DATA_W)) u_chan (
                .clk     (clk_bus),
                .rst     (rst_bus),
                .wr      (wr_hit[i]),
                .wdata   (wr_data),
                .hold    (freeze),
                .block   (blk[i]),
                .ack_i   (ack_vec[i]),
                .req_o   (req_vec[i]),
                .data_o  (xfer_data[i]),
                .busy_o  (busy[i]),
                .stall_o (stall[i])
            );

            rsync_dst #(.W(DATA_W), .PULSE(is_pulse_reg(i))) u_dst (
                .clk    (clk_cnt),
                .rst    (rst_cnt),
                .req_i  (req_vec[i]),
                .data_i (xfer_data[i]),
                .ack_o  (ack_vec[i]),
                .q_o    (slow_q[i])
            );
        end
    endgenerate

    // Reset-enable path: bypasses the handshake and any freeze
    always_ff @(posedge clk_bus) begin
        if (rst_bus) rsten_q <= 1'b0;
        else if (wr_hit[IDX_CTRL]) rsten_q <= wr_data[RSTEN_BIT];
    end

    assign cnt_rsten = rsten_q;
    assign cnt_ctrl  = slow_q[IDX_CTRL];
    assign cnt_top   = slow_q[IDX_TOPB];
    assign cnt_cmd   = slow_q[IDX_CMD];
    assign cnt_filt  = slow_q[IDX_FILT];

    // R3
    freeze_hold_chk: assert property (@(posedge clk_bus) disable iff (rst_bus)
        $past(freeze) |-> $stable(req_vec));

    // R6
    top_before_ctrl_chk: assert property (@(posedge clk_bus) disable iff (rst_bus)
        ((req_vec[IDX_CTRL] != $past(req_vec[IDX_CTRL])) && !$past(wr_hit[IDX_TOPB]))
        |-> !stall[IDX_TOPB]);
endmodule

// File: tb/sim_rsync_bridge.sv
module sim_rsync_bridge;
    localparam int DW = 8;

    logic          clk_bus = 1'b0;
    logic          clk_cnt = 1'b0;
    logic          rst_bus = 1'b1;
    logic          rst_cnt = 1'b1;
    logic          wr_en   = 1'b0;
    logic [1:0]    wr_sel  = '0;
    logic [DW-1:0] wr_data = '0;
    logic          freeze  = 1'b0;
    logic [3:0]    busy;
    logic [DW-1:0] cnt_ctrl, cnt_top, cnt_cmd, cnt_filt;
    logic          cnt_rsten;

    int tests = 0;
    int fails = 0;
    int slow_edges = 0;
    int cmd_pulses = 0;
    logic [DW-1:0] last_cmd = '0;
    bit finished = 0;

    always #4  clk_bus = ~clk_bus;
    always #17 clk_cnt = ~clk_cnt;

    always @(posedge clk_cnt) slow_edges <= slow_edges + 1;
    always @(negedge clk_cnt) if (cnt_cmd != '0) begin
        cmd_pulses <= cmd_pulses + 1;
        last_cmd   <= cnt_cmd;
    end

    rsync_bridge #(.DATA_W(DW), .RSTEN_BIT(7)) u0 (
        .clk_bus(clk_bus), .rst_bus(rst_bus), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .freeze(freeze), .busy(busy), .clk_cnt(clk_cnt),
        .rst_cnt(rst_cnt), .cnt_ctrl(cnt_ctrl), .cnt_top(cnt_top),
        .cnt_cmd(cnt_cmd), .cnt_filt(cnt_filt), .cnt_rsten(cnt_rsten)
    );

    // sel(2) | data(8)
    localparam logic [9:0] VEC [6] = '{
        {2'd0, 8'h12}, {2'd1, 8'h34}, {2'd3, 8'h56},
        {2'd1, 8'h9A}, {2'd0, 8'h0C}, {2'd3, 8'hE1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] slow_of(input logic [1:0] s);
        case (s)
            2'd0:    return cnt_ctrl;
            2'd1:    return cnt_top;
            2'd2:    return cnt_cmd;
            default: return cnt_filt;
        endcase
    endfunction

    // Called at a bus negedge; returns at the next bus negedge
    task automatic bus_write(input logic [1:0] s, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk_bus);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 400 && busy != '0; k++) @(negedge clk_bus);
    endtask

    initial begin
        repeat (100000) @(posedge clk_bus);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", busy, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (6) @(posedge clk_cnt);
        @(negedge clk_bus); rst_bus = 1'b0;
        @(negedge clk_cnt); rst_cnt = 1'b0;
        @(negedge clk_bus);

        // R9 reset state
        check(busy == '0, "R9 busy", busy, 0);
        check(cnt_ctrl == '0 && cnt_top == '0 && cnt_filt == '0 && cnt_cmd == '0,
              "R9 slow outputs", {cnt_ctrl, cnt_top}, 0);
        check(cnt_rsten == 1'b0, "R9 rsten", cnt_rsten, 0);

        // Table walk: R1 busy set, R2 delivery latency and busy clear
        foreach (VEC[v]) begin
            logic [1:0]    s;
            logic [DW-1:0] d;
            int            n0;
            int            lat;
            s = VEC[v][9:8];
            d = VEC[v][7:0];
            bus_write(s, d);
            check(busy[s] == 1'b1, "R1 busy after write", busy, 1 << s);
            @(posedge clk_bus); #1;
            n0 = slow_edges;
            for (int k = 0; k < 10 && slow_of(s) != d; k++) @(negedge clk_cnt);
            lat = slow_edges - n0;
            check(slow_of(s) == d, "R2 slow value", slow_of(s), d);
            check(lat <= 3, "R2 latency in slow edges", lat, 3);
            wait_idle();
            check(busy == '0, "R2 busy cleared", busy, 0);
            @(negedge clk_bus);
        end

        // R8 command pulse
        cmd_pulses = 0;
        bus_write(2'd2, 8'h5A);
        wait_idle();
        repeat (4) @(negedge clk_cnt);
        check(cmd_pulses == 1, "R8 pulse count", cmd_pulses, 1);
        check(last_cmd == 8'h5A, "R8 pulse value", last_cmd, 8'h5A);
        check(cnt_cmd == '0, "R8 idle zero", cnt_cmd, 0);

        // R3 freeze staging and R5 reset-enable bypass
        @(negedge clk_bus);
        freeze = 1'b1;
        bus_write(2'd0, 8'h91);
        check(cnt_rsten == 1'b1, "R5 rsten while frozen", cnt_rsten, 1);
        bus_write(2'd1, 8'h22);
        bus_write(2'd3, 8'h33);
        check(busy == 4'b1011, "R3 busy while frozen", busy, 4'b1011);
        repeat (30) @(negedge clk_bus);
        check(cnt_ctrl == 8'h0C && cnt_top == 8'h9A && cnt_filt == 8'hE1,
              "R3 outputs held", {cnt_ctrl, cnt_top, cnt_filt}, 24'h0C9AE1);

        // R4 release together
        freeze = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk_cnt);
            if (cnt_ctrl != 8'h0C || cnt_top != 8'h9A || cnt_filt != 8'hE1) break;
        end
        check(cnt_ctrl == 8'h91 && cnt_top == 8'h22 && cnt_filt == 8'h33,
              "R4 same edge release", {cnt_ctrl, cnt_top, cnt_filt}, 24'h912233);
        @(negedge clk_bus);
        wait_idle();
        check(busy == '0, "R4 busy cleared", busy, 0);

        // R5 reset-enable cleared
        @(negedge clk_bus);
        bus_write(2'd0, 8'h01);
        check(cnt_rsten == 1'b0, "R5 rsten cleared", cnt_rsten, 0);
        wait_idle();

        // R6 top value before control
        begin
            bit bad;
            bad = 0;
            @(negedge clk_bus);
            bus_write(2'd1, 8'h40);
            bus_write(2'd1, 8'h41);
            bus_write(2'd0, 8'h42);
            for (int k = 0; k < 60; k++) begin
                @(negedge clk_cnt);
                if (cnt_ctrl == 8'h42 && cnt_top != 8'h41) bad = 1;
                if (cnt_ctrl == 8'h42) break;
            end
            check(!bad, "R6 order violated", cnt_top, 8'h41);
            check(cnt_ctrl == 8'h42, "R6 ctrl delivered", cnt_ctrl, 8'h42);
            @(negedge clk_bus);
            wait_idle();
        end

        // R7 write while busy is re-sent
        begin
            bit gap;
            gap = 0;
            @(negedge clk_bus);
            bus_write(2'd3, 8'h70);
            bus_write(2'd3, 8'h71);
            for (int k = 0; k < 400 && busy[3]; k++) begin
                @(negedge clk_bus);
                if (cnt_filt != 8'h71 && !busy[3]) gap = 1;
            end
            check(!gap, "R7 busy dropped early", busy, 4'b1000);
            check(cnt_filt == 8'h71, "R7 final value", cnt_filt, 8'h71);
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule